// File: doc/BRIEF.md
# Counted Block Memory Copy Engine

This block moves a run of bytes from one place in memory to another through a single byte-wide memory port with a request/acknowledge handshake. A one-cycle start pulse captures a source pointer, a destination pointer and a byte count. The engine then loops: it reads one byte at the source pointer, writes that byte at the destination pointer, advances both pointers by one and lowers the count by one. The loop ends when the count reaches zero.

The count can be taken in two widths. In narrow mode only the low 8 bits of the count input are used. In wide mode all 16 bits are used. The count is tested before the first access, so a zero count finishes at once with no memory traffic. When the engine finishes, it raises a one-cycle done pulse. The pointer and count outputs then keep their post-copy values, so software or a following block can pick up where the copy ended.

Top module: `bcopy_engine`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are 0, and src_o, dst_o and cnt_o are all zero.
- R2: Each byte is moved by one read at the source pointer (mem_we_o=0), followed by one write of the same byte at the destination pointer (mem_we_o=1). Reads and writes strictly alternate, starting with a read.
- R3: After each byte, both pointers advance by one. The pointers are 32 bits wide and wrap from 32'hFFFF_FFFF to 0.
- R4: The count drops by one per byte, and exactly as many bytes are moved as the loaded count states.
- R5: If the loaded count is zero, the engine makes no memory request and pulses done_o in the first cycle after the start edge.
- R6: In narrow mode (wide_i=0), only cnt_i[7:0] is loaded, and cnt_i[15:8] has no effect.
- R7: In wide mode (wide_i=1), all 16 bits of cnt_i are loaded as the count.
- R8: When done_o is high, src_o and dst_o hold the start pointers plus the number of bytes moved, and cnt_o holds 0. These values stay until the next accepted start.
- R9: A start pulse that arrives while busy_o is high is ignored.
- R10: done_o is a one-cycle pulse, and busy_o is low in that cycle. busy_o is high from the cycle after a start with a nonzero count until done_o.
- R11: While mem_req_o is high and mem_ack_i is low, mem_addr_o, mem_we_o and mem_wdata_o hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle start pulse |
| wide_i | input | 1 | 1 selects the 16-bit count, 0 selects the 8-bit count |
| src_i | input | 32 | Source start address |
| dst_i | input | 32 | Destination start address |
| cnt_i | input | 16 | Byte count |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Access complete; read data is valid in this cycle |
| mem_rdata_i | input | 8 | Read data |
| busy_o | output | 1 | A copy is in progress |
| done_o | output | 1 | One-cycle pulse when a copy ends |
| src_o | output | 32 | Current source pointer |
| dst_o | output | 32 | Current destination pointer |
| cnt_o | output | 16 | Remaining byte count |

## Verification
A wrong count or a wrong loop exit shows up as the wrong number of reads and writes, and as a done pulse that comes early or late. Both are visible at the port within one byte of the fault. A wrong pointer step shows up on the very next request address, and later as wrong destination contents and wrong final pointers. A lost or mixed-up data byte shows up in the destination memory once the copy ends. A handshake fault shows up as a changed address or direction during a stalled request in the same cycle it happens. Memory latencies of zero to two cycles are used, so that the stall paths are exercised.

// File: rtl/bcopy_pkg.sv
// Shared types and constants for the block copy engine.
// Assumes byte-wide data and a single outstanding memory access.
package bcopy_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_FIN  = 2'd3
    } bc_state_e;
endpackage

// File: rtl/bcopy_fsm.sv
// Sequencer of the copy loop: idle, read, write and finish.
// Assumes the memory acknowledge is a single-cycle pulse per access.
module bcopy_fsm
    import bcopy_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      zero_load_i,
    input  logic      last_i,
    input  logic      ack_i,
    output bc_state_e state_o,
    output logic      load_o,
    output logic      capture_o,
    output logic      step_o,
    output logic      busy_o,
    output logic      done_o
);
    bc_state_e state_q, state_d;

    assign busy_o    = (state_q == ST_RD) || (state_q == ST_WR);
    assign done_o    = (state_q == ST_FIN);
    assign load_o    = start_i && !busy_o;
    assign capture_o = (state_q == ST_RD) && ack_i;
    assign step_o    = (state_q == ST_WR) && ack_i;
    assign state_o   = state_q;

    // Next-state selection for the copy loop.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_FIN: begin
                if (load_o) state_d = zero_load_i ? ST_FIN : ST_RD;
                else        state_d = ST_IDLE;
            end
            ST_RD:   if (ack_i) state_d = ST_WR;
            ST_WR:   if (ack_i) state_d = last_i ? ST_FIN : ST_RD;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o); // R10
    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD && ack_i) |=> (state_q == ST_WR)); // R2
endmodule

// File: rtl/bcopy_ptr.sv
// Address pointer: loads a start value and steps up by one, wrapping.
// Assumes load and step are never active together.
module bcopy_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] val_i,
    input  logic          step_i,
    output logic [AW-1:0] q_o
);
    logic [AW-1:0] q;
    assign q_o = q;

    // Pointer register: load, post-increment or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (load_i) q <= val_i;
        else if (step_i) q <= q + AW'(1);
    end
endmodule

// File: rtl/bcopy_cnt.sv
// Byte counter with a narrow or a wide load width.
// Assumes the decrement is only requested while the count is nonzero.
module bcopy_cnt #(
    parameter int NW = 8,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          wide_i,
    input  logic [WW-1:0] val_i,
    input  logic          dec_i,
    output logic [WW-1:0] q_o,
    output logic          zero_load_o,
    output logic          last_o
);
    logic [WW-1:0] q;
    logic [WW-1:0] masked;

    // Pick the load value by mode; the narrow form zero-extends.
    generate
        if (WW > NW) begin : g_mask
            assign masked = wide_i ? val_i : {{(WW-NW){1'b0}}, val_i[NW-1:0]};
        end else begin : g_nomask
            assign masked = val_i;
        end
    endgenerate

    assign zero_load_o = (masked == '0);
    assign last_o      = (q == WW'(1));
    assign q_o         = q;

    // Count register: load, decrement or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (load_i) q <= masked;
        else if (dec_i)  q <= q - WW'(1);
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (q != '0)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |=> (q == $past(q) - WW'(1))); // R4
endmodule

// File: rtl/bcopy_engine.sv
// Counted byte copy engine: reads each byte at the source pointer, then
// writes it at the destination pointer. It steps both pointers and the
// count, and stops when the count is zero. Assumes a memory slave that
// answers each request with a one-cycle acknowledge.
module bcopy_engine
    import bcopy_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8,
    parameter int NW = 8,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wide_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [WW-1:0] cnt_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [WW-1:0] cnt_o
);
    localparam int NPTR = 2;

    bc_state_e     state;
    logic          load, capture, step, zero_load, last;
    logic [DW-1:0] data_q;
    logic [AW-1:0] ptr_init [NPTR];
    logic [AW-1:0] ptr_q    [NPTR];

    bcopy_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .zero_load_i(zero_load),
        .last_i     (last),
        .ack_i      (mem_ack_i),
        .state_o    (state),
        .load_o     (load),
        .capture_o  (capture),
        .step_o     (step),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    assign ptr_init[0] = src_i;
    assign ptr_init[1] = dst_i;

    generate
        for (genvar i = 0; i < NPTR; i++) begin : g_ptr
            bcopy_ptr #(.AW(AW)) u_ptr (
                .clk   (clk),
                .rst_n (rst_n),
                .load_i(load),
                .val_i (ptr_init[i]),
                .step_i(step),
                .q_o   (ptr_q[i])
            );
        end
    endgenerate

    bcopy_cnt #(.NW(NW), .WW(WW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .wide_i     (wide_i),
        .val_i      (cnt_i),
        .dec_i      (step),
        .q_o        (cnt_o),
        .zero_load_o(zero_load),
        .last_o     (last)
    );

    // Hold the byte just read until it has been written.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= mem_rdata_i;
    end

    assign src_o       = ptr_q[0];
    assign dst_o       = ptr_q[1];
    assign mem_req_o   = busy_o;
    assign mem_we_o    = (state == ST_WR);
    assign mem_addr_o  = (state == ST_WR) ? ptr_q[1] : ptr_q[0];
    assign mem_wdata_o = data_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o))); // R11
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ack_i)
            |=> (src_o == $past(src_o) + AW'(1))); // R3
    AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cnt_o == '0)); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !mem_ack_i) |=> $stable(cnt_o)); // R9
endmodule

// File: tb/bcopy_engine_bench.sv
module bcopy_engine_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0, wide_i = 0;
    logic [31:0] src_i = 0, dst_i = 0;
    logic [15:0] cnt_i = 0;
    logic        mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        busy_o, done_o;
    logic [31:0] src_o, dst_o;
    logic [15:0] cnt_o;

    int checks = 0, failures = 0, cycles = 0;
    int lat = 0, wcnt = 0;
    int n_rd = 0, n_wr = 0, ord_err = 0, hold_err = 0;
    bit last_rd = 0, clr = 0;
    logic [7:0] mem [1024];
    logic [7:0] expd [1024];
    logic        p_req = 0, p_we = 0, p_ack = 0;
    logic [31:0] p_addr = 0;

    always #2.5 clk = ~clk;

    bcopy_engine u_bcopy_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o)
    );

    // Memory slave with programmable latency and an access-order monitor.
    always @(posedge clk) begin
        if (clr) begin
            n_rd <= 0; n_wr <= 0; ord_err <= 0; hold_err <= 0;
            last_rd <= 0; mem_ack_i <= 0; wcnt <= 0;
        end else if (mem_req_o && !mem_ack_i) begin
            if (wcnt >= lat) begin
                mem_ack_i <= 1; wcnt <= 0;
                if (mem_we_o) begin
                    mem[mem_addr_o[9:0]] <= mem_wdata_o;
                    n_wr <= n_wr + 1;
                    if (!last_rd) ord_err <= ord_err + 1;
                    last_rd <= 0;
                end else begin
                    mem_rdata_i <= mem[mem_addr_o[9:0]];
                    n_rd <= n_rd + 1;
                    if (last_rd) ord_err <= ord_err + 1;
                    last_rd <= 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack_i <= 0;
        end
    end

    // Stall stability monitor for the request fields.
    always @(negedge clk) begin
        if (!clr && p_req && !p_ack && mem_req_o &&
            (mem_addr_o != p_addr || mem_we_o != p_we))
            hold_err <= hold_err + 1;
        p_req <= mem_req_o; p_ack <= mem_ack_i; p_addr <= mem_addr_o; p_we <= mem_we_o;
    end

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'(i * 7 + 3);
            expd[i] = mem[i];
        end
    endtask

    task automatic clear_stats();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    task automatic pulse_start(input logic [31:0] s, input logic [31:0] d,
                               input logic [15:0] c, input logic w);
        src_i = s; dst_i = d; cnt_i = c; wide_i = w; start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    // r1_ reset state
    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && mem_req_o == 0, "R1 ctrl", {busy_o, done_o, mem_req_o}, 0);
        chk(src_o == 0 && dst_o == 0 && cnt_o == 0, "R1 regs", src_o | dst_o | cnt_o, 0);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Full copy with result checks for R2, R3, R4, R8, R10, R11.
    task automatic t_copy(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c,
                          input logic w, input int l, input string tag);
        int n, guard;
        bit busy_bad;
        n = w ? int'(c) : int'(c[7:0]);
        lat = l;
        fill_mem();
        clear_stats();
        for (int i = 0; i < n; i++) expd[10'(d + 32'(i))] = expd[10'(s + 32'(i))];
        pulse_start(s, d, c, w);
        guard = 0; busy_bad = 0;
        while (!done_o && guard < 5000) begin
            if (!busy_o) busy_bad = 1;
            @(negedge clk); guard++;
        end
        chk(done_o == 1, {tag, " R10 done seen"}, done_o, 1);
        chk(busy_bad == 0 && busy_o == 0, {tag, " R10 busy window"}, busy_bad, 0);
        chk(n_rd == n && n_wr == n, {tag, " R4 access count"}, n_rd + n_wr, 2 * n);
        chk(ord_err == 0, {tag, " R2 read-write order"}, ord_err, 0);
        chk(hold_err == 0, {tag, " R11 stall hold"}, hold_err, 0);
        chk(src_o == s + 32'(n), {tag, " R3 src final"}, src_o, s + 32'(n));
        chk(dst_o == d + 32'(n), {tag, " R3 dst final"}, dst_o, d + 32'(n));
        chk(cnt_o == 0, {tag, " R8 count zero"}, cnt_o, 0);
        begin
            int bad = 0;
            for (int i = 0; i < 1024; i++) if (mem[i] !== expd[i]) bad++;
            chk(bad == 0, {tag, " R2 data copied"}, bad, 0);
        end
        @(negedge clk);
        chk(done_o == 0, {tag, " R10 single pulse"}, done_o, 0);
        chk(src_o == s + 32'(n) && cnt_o == 0, {tag, " R8 held"}, src_o, s + 32'(n));
    endtask

    // r5_ zero count
    task automatic t_zero();
        clear_stats();
        pulse_start(32'h10, 32'h300, 16'h0000, 1'b1);
        chk(done_o == 1 && busy_o == 0, "R5 immediate done", {done_o, busy_o}, 2'b10);
        chk(src_o == 32'h10 && dst_o == 32'h300, "R5 pointers unmoved", src_o, 32'h10);
        repeat (3) @(negedge clk);
        chk(n_rd == 0 && n_wr == 0, "R5 no access", n_rd + n_wr, 0);
        pulse_start(32'h10, 32'h300, 16'h0500, 1'b0);
        chk(done_o == 1 && n_rd == 0, "R6 narrow zero ignores upper bits", done_o, 1);
        @(negedge clk);
    endtask

    // r9_ start while busy
    task automatic t_ignore();
        int guard = 0;
        lat = 1;
        fill_mem();
        clear_stats();
        pulse_start(32'h40, 32'h240, 16'd5, 1'b0);
        repeat (3) @(negedge clk);
        pulse_start(32'h80, 32'h380, 16'd9, 1'b0);
        while (!done_o && guard < 2000) begin @(negedge clk); guard++; end
        chk(src_o == 32'h45 && dst_o == 32'h245, "R9 start ignored ptrs", src_o, 32'h45);
        chk(n_wr == 5, "R9 start ignored count", n_wr, 5);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_copy(32'h0000_0000, 32'h0000_0200, 16'd1,    1'b0, 0, "single");
        t_copy(32'h0000_0010, 32'h0000_0220, 16'd6,    1'b0, 2, "stall");
        t_copy(32'hFFFF_FFFE, 32'h0000_0200, 16'd4,    1'b1, 1, "R3 wrap");
        t_copy(32'h0000_0020, 32'h0000_0280, 16'h0103, 1'b0, 0, "R6 narrow");
        t_copy(32'h0000_0000, 32'h0000_0200, 16'h0102, 1'b1, 1, "R7 wide");
        t_zero();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule